// File: doc/BRIEF.md
# Strapped Management-Bus Address Decoder

This block sits on the switch side of a serial management link, behind the logic that has already turned the bit stream into frames. Each frame carries a 5-bit bus address, a 5-bit register number, a direction and, for writes, a 16-bit value. Four strap inputs and a dual-device select decide which frames the device answers and how each one reaches the internal register devices. Those devices sit on a simple internal bus that uses a request/acknowledge handshake.

Three addressing schemes are possible, and they are chosen from the straps while the block runs. With all four straps low, every bus address maps straight onto the internal device of the same number. With any strap high, the device answers only at its own even address, and only through a command register and a data register that form an indirect window. A busy flag in the command register tracks each internal access. With the dual select high, only the top strap counts: the device answers the half of the address space that strap picks, and it subtracts the base address to find the internal device.

Each frame gets exactly one response pulse. The upstream side sends no new frame until the previous response has appeared.

Top module: `smi_addr_decoder`

## Requirements
- R1: The device's own bus address is formed from `strap_addr` as bits 4 to 1, with bit 0 always zero. In indirect-window mode, only frames to that address at register 0 (command) or register 1 (data) are answered.
- R2: With `dual_sel` low and `strap_addr` zero, every frame is answered and passed to the internal bus as a request. The request carries device = bus address, register = frame register, plus the frame's direction and write value.
- R3: In indirect-window mode, a frame to any other bus address, or to registers 2 to 31 at the own address, gets a response with `rsp_hit` low and `rsp_data` all ones, and raises no internal request.
- R4: The command register layout is: bit 15 is busy, bits 14:10 are the operation field, bits 9:5 are the internal device and bits 4:0 are the internal register. Operation field 5'b00110 means read and 5'b00101 means write. A command write with a known operation stores bits 14:0. If its bit 15 is also set, it starts an internal access with those fields.
- R5: A command write whose operation field is neither known value is ignored. Busy stays clear, no request is raised, and the command register reads back unchanged.
- R6: An indirect read loads the acknowledged internal value into the data register and clears busy.
- R7: An indirect write drives the current data-register value on `ib_wdata` and clears busy on the acknowledge.
- R8: `ib_req` holds its device, register, direction and write value stable until `ib_ack`. It drops on the cycle after the acknowledge. Busy is set for at least one cycle and clears only with the acknowledge. After reset, no request or response is pending and both window registers read zero.
- R9: While busy is set, writes to the command or data register are ignored. A command-register read returns busy = 1 together with the stored fields.
- R10: With `dual_sel` high, a frame is answered when bus address bit 4 equals `strap_addr[3]`. The internal device is the bus address minus `{strap_addr[3],4'b0000}`. Other frames get the miss response of R3.
- R11: Window and miss responses appear one cycle after the frame. A direct-mapped response appears one cycle after the acknowledge cycle and carries `ib_rdata` for reads. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 4 | Strapped address bits 4 to 1 |
| dual_sel | input | 1 | Selects the half-address-space dual scheme |
| frm_valid | input | 1 | One-cycle pulse marking a decoded frame |
| frm_phy | input | 5 | Frame bus address |
| frm_reg | input | 5 | Frame register number |
| frm_write | input | 1 | Frame is a write |
| frm_wdata | input | 16 | Frame write value |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Frame was answered by this device |
| rsp_data | output | 16 | Read value, zero for writes, all ones on a miss |
| ib_req | output | 1 | Internal bus request |
| ib_write | output | 1 | Internal access is a write |
| ib_dev | output | 5 | Internal device number |
| ib_reg | output | 5 | Internal register number |
| ib_wdata | output | 16 | Internal write value |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 16 | Internal read value, valid with the acknowledge |

## Verification
A wrong busy flag shows on the very next command-register read. It also shows as a request that outlives its acknowledge, or as a data register that took a write it should have dropped, and that surfaces on the next data read. A wrong address decode shows one cycle after the frame, as a hit where all ones was due or as an internal request with the wrong device number. The bench therefore reads the window back after every indirect step, and it compares the device number on each request with a value it derives from the straps itself.

// File: rtl/smi_dec_pkg.sv
package smi_dec_pkg;
  localparam int STRAP_W = 4;
  localparam int ADDR_W  = STRAP_W + 1;
  localparam int DATA_W  = 16;
  localparam int OPF_W   = 5;

  localparam int BUSY_BIT = DATA_W - 1;
  localparam int OPF_LO   = 2 * ADDR_W;
  localparam int OPF_HI   = OPF_LO + OPF_W - 1;

  localparam logic [OPF_W-1:0] OPF_READ  = 5'b00110;
  localparam logic [OPF_W-1:0] OPF_WRITE = 5'b00101;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_MULTI  = 2'd1,
    MODE_DUAL   = 2'd2
  } smi_mode_e;

  function automatic smi_mode_e pick_mode(input logic [STRAP_W-1:0] strap,
                                          input logic dual);
    if (dual) return MODE_DUAL;
    if (strap == '0) return MODE_SINGLE;
    return MODE_MULTI;
  endfunction

  function automatic logic [ADDR_W-1:0] own_addr(input logic [STRAP_W-1:0] strap);
    return {strap, 1'b0};
  endfunction

  function automatic logic [ADDR_W-1:0] dual_base(input logic [STRAP_W-1:0] strap);
    return {strap[STRAP_W-1], {(ADDR_W-1){1'b0}}};
  endfunction

  function automatic logic op_known(input logic [OPF_W-1:0] opf);
    return (opf == OPF_READ) || (opf == OPF_WRITE);
  endfunction
endpackage

// File: rtl/smi_strap_decode.sv
module smi_strap_decode
  import smi_dec_pkg::*;
(
  input  logic [STRAP_W-1:0] strap,
  input  logic               dual,
  input  logic [ADDR_W-1:0]  phy,
  input  logic [ADDR_W-1:0]  regn,
  output smi_mode_e          mode,
  output logic               hit_direct,
  output logic               hit_window,
  output logic [ADDR_W-1:0]  dev_map
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    mode       = pick_mode(strap, dual);
    base       = dual_base(strap);
    hit_direct = 1'b0;
    hit_window = 1'b0;
    dev_map    = phy;
    case (mode)
      MODE_SINGLE: hit_direct = 1'b1;
      MODE_DUAL: begin
        hit_direct = (phy[ADDR_W-1] == base[ADDR_W-1]);
        dev_map    = phy - base;
      end
      default: hit_window = (phy == own_addr(strap)) && (regn[ADDR_W-1:1] == '0);
    endcase
  end
endmodule

// File: rtl/smi_ibus_master.sv
module smi_ibus_master
  import smi_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              st_write,
  input  logic [ADDR_W-1:0] st_dev,
  input  logic [ADDR_W-1:0] st_reg,
  input  logic [DATA_W-1:0] st_wdata,
  output logic              ib_req,
  output logic              ib_write,
  output logic [ADDR_W-1:0] ib_dev,
  output logic [ADDR_W-1:0] ib_reg,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic              ib_ack,
  output logic              done
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      ib_write <= 1'b0;
      ib_dev   <= '0;
      ib_reg   <= '0;
      ib_wdata <= '0;
    end else if (start && !req_q) begin
      req_q    <= 1'b1;
      ib_write <= st_write;
      ib_dev   <= st_dev;
      ib_reg   <= st_reg;
      ib_wdata <= st_wdata;
    end else if (req_q && ib_ack) begin
      req_q <= 1'b0;
    end
  end

  assign ib_req = req_q;
  assign done   = req_q & ib_ack;
endmodule

// File: rtl/smi_cmd_window.sv
module smi_cmd_window
  import smi_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_write,
  input  logic              acc_sel,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] done_rdata,
  output logic              busy,
  output logic [DATA_W-1:0] cmd_view,
  output logic [DATA_W-1:0] data_q,
  output logic              start,
  output logic              st_write,
  output logic [ADDR_W-1:0] st_dev,
  output logic [ADDR_W-1:0] st_reg
);
  logic [DATA_W-2:0] fields_q;
  logic [OPF_W-1:0]  opf;
  logic              cmd_wr, data_wr, fin;

  assign opf      = acc_wdata[OPF_HI:OPF_LO];
  assign cmd_wr   = acc && acc_write && !acc_sel && !busy && op_known(opf);
  assign data_wr  = acc && acc_write && acc_sel && !busy;
  assign start    = cmd_wr && acc_wdata[BUSY_BIT];
  assign st_write = (opf == OPF_WRITE);
  assign st_dev   = acc_wdata[2*ADDR_W-1:ADDR_W];
  assign st_reg   = acc_wdata[ADDR_W-1:0];
  assign fin      = busy && done;
  assign cmd_view = {busy, fields_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      fields_q <= '0;
      data_q   <= '0;
    end else begin
      if (cmd_wr) fields_q <= acc_wdata[DATA_W-2:0];
      if (start) busy <= 1'b1;
      else if (fin) busy <= 1'b0;
      if (fin && (fields_q[OPF_HI:OPF_LO] == OPF_READ)) data_q <= done_rdata;
      else if (data_wr) data_q <= acc_wdata;
    end
  end
endmodule

// File: rtl/smi_addr_decoder.sv
module smi_addr_decoder
  import smi_dec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               dual_sel,
  input  logic               frm_valid,
  input  logic [ADDR_W-1:0]  frm_phy,
  input  logic [ADDR_W-1:0]  frm_reg,
  input  logic               frm_write,
  input  logic [DATA_W-1:0]  frm_wdata,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               ib_req,
  output logic               ib_write,
  output logic [ADDR_W-1:0]  ib_dev,
  output logic [ADDR_W-1:0]  ib_reg,
  output logic [DATA_W-1:0]  ib_wdata,
  input  logic               ib_ack,
  input  logic [DATA_W-1:0]  ib_rdata
);
  smi_mode_e         mode;
  logic              hit_direct, hit_window;
  logic [ADDR_W-1:0] dev_map;
  logic              mst_done;
  logic              win_busy;
  logic [DATA_W-1:0] win_cmd, win_data;
  logic              w_start, w_write;
  logic [ADDR_W-1:0] w_dev, w_reg;
  logic              d_start, m_start, m_write;
  logic [ADDR_W-1:0] m_dev, m_reg;
  logic [DATA_W-1:0] m_wdata;
  logic              dir_pend_q, dir_wr_q;

  smi_strap_decode u_dec (
    .strap(strap_addr), .dual(dual_sel), .phy(frm_phy), .regn(frm_reg),
    .mode(mode), .hit_direct(hit_direct), .hit_window(hit_window), .dev_map(dev_map)
  );

  smi_cmd_window u_win (
    .clk(clk), .rst_n(rst_n),
    .acc(frm_valid && hit_window), .acc_write(frm_write), .acc_sel(frm_reg[0]),
    .acc_wdata(frm_wdata), .done(mst_done), .done_rdata(ib_rdata),
    .busy(win_busy), .cmd_view(win_cmd), .data_q(win_data),
    .start(w_start), .st_write(w_write), .st_dev(w_dev), .st_reg(w_reg)
  );

  assign d_start = frm_valid && hit_direct && !ib_req && !dir_pend_q;
  assign m_start = d_start || w_start;
  assign m_write = d_start ? frm_write : w_write;
  assign m_dev   = d_start ? dev_map   : w_dev;
  assign m_reg   = d_start ? frm_reg   : w_reg;
  assign m_wdata = d_start ? frm_wdata : win_data;

  smi_ibus_master u_mst (
    .clk(clk), .rst_n(rst_n),
    .start(m_start), .st_write(m_write), .st_dev(m_dev), .st_reg(m_reg), .st_wdata(m_wdata),
    .ib_req(ib_req), .ib_write(ib_write), .ib_dev(ib_dev), .ib_reg(ib_reg),
    .ib_wdata(ib_wdata), .ib_ack(ib_ack), .done(mst_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_pend_q <= 1'b0;
      dir_wr_q   <= 1'b0;
    end else if (d_start) begin
      dir_pend_q <= 1'b1;
      dir_wr_q   <= frm_write;
    end else if (mst_done) begin
      dir_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else if (mst_done && dir_pend_q) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= 1'b1;
      rsp_data  <= dir_wr_q ? '0 : ib_rdata;
    end else if (frm_valid && !hit_direct) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= hit_window;
      if (!hit_window) rsp_data <= '1;
      else if (frm_write) rsp_data <= '0;
      else rsp_data <= frm_reg[0] ? win_data : win_cmd;
    end else begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/smi_dec_checker.sv
module smi_dec_checker
  import smi_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic [ADDR_W-1:0] frm_phy,
  input logic              hit_window,
  input smi_mode_e         mode,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic              ib_req,
  input logic              ib_ack,
  input logic              ib_write,
  input logic [ADDR_W-1:0] ib_dev,
  input logic [ADDR_W-1:0] ib_reg,
  input logic [DATA_W-1:0] ib_wdata,
  input logic              win_busy,
  input logic [DATA_W-1:0] win_data,
  input logic              mst_done
);
  assert_even_own_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && hit_window && mode == MODE_MULTI |-> frm_phy[0] == 1'b0);

  assert_miss_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_data == '1);

  assert_wdata_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy && ib_write |-> ib_wdata == win_data);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && !ib_ack |=> ib_req && $stable(ib_dev) && $stable(ib_reg)
                          && $stable(ib_write) && $stable(ib_wdata));

  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req && ib_ack |=> !ib_req);

  assert_busy_has_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy |-> ib_req);

  assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy && !mst_done |=> $stable(win_data));
endmodule

bind smi_addr_decoder smi_dec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_phy(frm_phy),
  .hit_window(hit_window), .mode(mode), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_data(rsp_data), .ib_req(ib_req), .ib_ack(ib_ack), .ib_write(ib_write),
  .ib_dev(ib_dev), .ib_reg(ib_reg), .ib_wdata(ib_wdata), .win_busy(win_busy),
  .win_data(win_data), .mst_done(mst_done)
);

// File: tb/test_smi_addr_decoder.sv
module test_smi_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap_addr = '0;
  logic        dual_sel = 1'b0;
  logic        frm_valid = 1'b0;
  logic [4:0]  frm_phy = '0;
  logic [4:0]  frm_reg = '0;
  logic        frm_write = 1'b0;
  logic [15:0] frm_wdata = '0;
  logic        rsp_valid, rsp_hit;
  logic [15:0] rsp_data;
  logic        ib_req, ib_write;
  logic [4:0]  ib_dev, ib_reg;
  logic [15:0] ib_wdata;
  logic        ib_ack = 1'b0;
  logic [15:0] ib_rdata = '0;

  int runs = 0;
  int fails = 0;
  logic auto_ack = 1'b1;

  always #5 clk = ~clk;

  smi_addr_decoder i_smi_addr_decoder (.*);

  // entry: strap[21:18] dual[17] phy[16:12] reg[11:7] kind[6:5] dev[4:0]
  // kind: 0 miss, 1 direct, 2 window
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {4'h0, 1'b0, 5'd0,  5'd3,  2'd1, 5'd0},
    {4'h0, 1'b0, 5'd31, 5'd17, 2'd1, 5'd31},
    {4'h0, 1'b0, 5'd13, 5'd0,  2'd1, 5'd13},
    {4'h3, 1'b0, 5'd6,  5'd0,  2'd2, 5'd0},
    {4'h3, 1'b0, 5'd6,  5'd1,  2'd2, 5'd0},
    {4'h3, 1'b0, 5'd6,  5'd2,  2'd0, 5'd0},
    {4'h3, 1'b0, 5'd7,  5'd0,  2'd0, 5'd0},
    {4'h3, 1'b0, 5'd0,  5'd0,  2'd0, 5'd0},
    {4'h8, 1'b1, 5'd16, 5'd5,  2'd1, 5'd0},
    {4'h8, 1'b1, 5'd25, 5'd2,  2'd1, 5'd9},
    {4'h8, 1'b1, 5'd3,  5'd0,  2'd0, 5'd0},
    {4'h0, 1'b1, 5'd5,  5'd4,  2'd1, 5'd5},
    {4'h0, 1'b1, 5'd20, 5'd1,  2'd0, 5'd0},
    {4'h6, 1'b1, 5'd4,  5'd8,  2'd1, 5'd4}
  };

  function automatic logic [15:0] pat(input logic [4:0] d, input logic [4:0] r);
    return {1'b1, d, r, 5'h15};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sends one frame, services the internal bus when auto_ack is set
  task automatic frame(input logic [4:0] p, input logic [4:0] r, input logic w,
                       input logic [15:0] wd, output logic h, output logic [15:0] d,
                       output logic sawreq, output logic [4:0] qdev,
                       output logic [4:0] qreg, output logic qw,
                       output logic [15:0] qwd, output int lat);
    logic got;
    got = 1'b0; sawreq = 1'b0; h = 1'b0; d = '0; lat = -1;
    qdev = '0; qreg = '0; qw = 1'b0; qwd = '0;
    @(negedge clk);
    frm_valid = 1'b1; frm_phy = p; frm_reg = r; frm_write = w; frm_wdata = wd;
    @(negedge clk);
    frm_valid = 1'b0;
    for (int k = 0; k < 50; k++) begin
      if (rsp_valid) begin
        h = rsp_hit; d = rsp_data; lat = k; got = 1'b1;
        break;
      end
      if (ib_req && auto_ack) begin
        sawreq = 1'b1; qdev = ib_dev; qreg = ib_reg; qw = ib_write; qwd = ib_wdata;
        ib_ack = 1'b1; ib_rdata = pat(ib_dev, ib_reg);
      end else begin
        ib_ack = 1'b0;
      end
      @(negedge clk);
    end
    ib_ack = 1'b0;
    check(got, "R11 response present", {31'd0, got}, 32'd1);
  endtask

  logic        h, sr, qw;
  logic [15:0] d, qwd;
  logic [4:0]  qd, qr;
  int          lat;

  task automatic wr(input logic [4:0] r, input logic [15:0] v);
    frame(5'd6, r, 1'b1, v, h, d, sr, qd, qr, qw, qwd, lat);
  endtask
  task automatic rd(input logic [4:0] r);
    frame(5'd6, r, 1'b0, 16'h0, h, d, sr, qd, qr, qw, qwd, lat);
  endtask

  initial begin
    #(10 * 100000);
    fails++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!rsp_valid && !ib_req, "R8 reset idle", {rsp_valid, ib_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [4:0] edev;
      strap_addr = VEC[i][21:18];
      dual_sel   = VEC[i][17];
      kind       = VEC[i][6:5];
      edev       = VEC[i][4:0];
      frame(VEC[i][16:12], VEC[i][11:7], 1'b0, 16'h0, h, d, sr, qd, qr, qw, qwd, lat);
      if (kind == 2'd1) begin
        // R2 single-chip / R10 dual: device mapping and read data
        check(sr && qd == edev && qr == VEC[i][11:7],
              dual_sel ? "R10 direct mapping" : "R2 direct mapping", {qd, qr}, {edev, VEC[i][11:7]});
        check(h && d == pat(edev, VEC[i][11:7]) && lat == 1,
              "R11 direct read response", d, pat(edev, VEC[i][11:7]));
      end else if (kind == 2'd2) begin
        // R1 own address, window registers zero after reset (R8)
        check(h && d == 16'h0 && !sr && lat == 0, "R1 window hit", {h, d}, {1'b1, 16'h0});
      end else begin
        check(!h && d == 16'hFFFF && !sr && lat == 0,
              dual_sel ? "R10 dual miss" : "R3 miss all ones", {sr, h, d}, {2'b00, 16'hFFFF});
      end
    end

    // R2: direct write passes value and returns zero data
    strap_addr = 4'h0; dual_sel = 1'b0;
    frame(5'd9, 5'd12, 1'b1, 16'h5AA5, h, d, sr, qd, qr, qw, qwd, lat);
    check(sr && qw && qwd == 16'h5AA5 && qd == 5'd9, "R2 direct write", qwd, 16'h5AA5);
    check(h && d == 16'h0 && lat == 1, "R11 write response zero", d, 16'h0);

    strap_addr = 4'h3; dual_sel = 1'b0;
    // R5: unknown opcode ignored
    wr(5'd0, 16'h8000 | (16'h1F << 10) | 16'h0123);
    check(!sr && !ib_req, "R5 no request", {31'd0, ib_req}, 0);
    rd(5'd0);
    check(d == 16'h0, "R5 command unchanged", d, 16'h0);

    // R4: known opcode without busy stores fields only
    wr(5'd0, 16'h1841);
    check(!ib_req, "R4 no start without busy bit", {31'd0, ib_req}, 0);
    rd(5'd0);
    check(d == 16'h1841, "R4 fields stored", d, 16'h1841);

    // R4/R6/R9: indirect read with delayed acknowledge
    auto_ack = 1'b0;
    wr(5'd0, 16'h8000 | 16'h1800 | (16'd9 << 5) | 16'd4);
    check(ib_req && !ib_write && ib_dev == 5'd9 && ib_reg == 5'd4, "R4 read started",
          {ib_req, ib_write, ib_dev, ib_reg}, {1'b1, 1'b0, 5'd9, 5'd4});
    rd(5'd0);
    check(d == 16'h9924, "R9 busy visible", d, 16'h9924);
    wr(5'd1, 16'h1234);
    wr(5'd0, 16'h8000 | 16'h1400 | 16'h0011);
    repeat (3) @(negedge clk);
    check(ib_req && ib_dev == 5'd9 && !ib_write, "R8 request held", {ib_req, ib_dev}, {1'b1, 5'd9});
    ib_ack = 1'b1; ib_rdata = 16'hBEEF;
    @(negedge clk);
    ib_ack = 1'b0;
    check(!ib_req, "R8 request dropped", {31'd0, ib_req}, 0);
    auto_ack = 1'b1;
    rd(5'd0);
    check(d == 16'h1924, "R6 busy cleared, R9 fields kept", d, 16'h1924);
    rd(5'd1);
    check(d == 16'hBEEF, "R6 read data loaded", d, 16'hBEEF);

    // R7/R9: indirect write, data write during busy ignored
    wr(5'd1, 16'hA5C3);
    auto_ack = 1'b0;
    wr(5'd0, 16'h947E);
    check(ib_req && ib_write && ib_wdata == 16'hA5C3 && ib_dev == 5'd3 && ib_reg == 5'd30,
          "R7 write uses data register", ib_wdata, 16'hA5C3);
    wr(5'd1, 16'h0F0F);
    ib_ack = 1'b1;
    @(negedge clk);
    ib_ack = 1'b0;
    auto_ack = 1'b1;
    rd(5'd1);
    check(d == 16'hA5C3, "R9 data write ignored while busy", d, 16'hA5C3);
    rd(5'd0);
    check(d == 16'h147E, "R7 busy cleared", d, 16'h147E);

    // R1: odd neighbour of own address stays silent
    frame(5'd7, 5'd1, 1'b0, 16'h0, h, d, sr, qd, qr, qw, qwd, lat);
    check(!h && d == 16'hFFFF, "R1 odd address miss", d, 16'hFFFF);

    // R8: reset clears window
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(5'd1);
    check(d == 16'h0, "R8 data reset", d, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule